// File: doc/BRIEF.md
# Aliased Vector/Scalar Register File

This block holds thirty-two 128-bit vector registers and presents the same storage through a second, narrower view: the low 64 bits of every vector register act as that register's 64-bit scalar floating-point register. There is no separate scalar storage. A scalar write therefore changes what the vector ports see, and a vector write changes what the scalar port sees.

The vector side has two independent combinational read ports and one write port. A format input on the write port chooses between replacing the whole register and replacing only its low doubleword. The scalar side has one read port and one write port that reach only the low 64 bits. When the vector and scalar writes hit the same register in the same cycle, the vector write wins and a flag reports the clash. Every read path, including a fourth port that extracts one byte, halfword, word or doubleword element by index, sees a write that is pending in the same cycle. Writes commit on the rising clock edge.

Top module: `vreg_alias_file`

## Requirements
- R1: A synchronous active-high reset clears all 32 registers, each 128 bits wide, so that every read port returns zero afterwards.
- R2: A vector write with `vw_full`=1 stores all 128 bits of `vw_data`, and both vector read ports return them from the next cycle.
- R3: A vector write with `vw_full`=0 replaces bits 63:0 with `vw_data[63:0]` and leaves bits 127:64 of the register unchanged.
- R4: A scalar write stores `sw_data` in bits 63:0 of the register and clears bits 127:64 to zero.
- R5: The scalar read port returns bits 63:0 of the addressed vector register.
- R6: When a vector write and a scalar write address the same register in one cycle, only the vector write takes effect and `wr_clash` is 1 in that cycle; otherwise `wr_clash` is 0.
- R7: Every read port returns, in the same cycle, the value the addressed register will hold after a write pending in that cycle.
- R8: The extract port uses format code 0 for byte, 1 for halfword, 2 for word and 3 for doubleword; element n of width w is register bits [n*w+w-1 : n*w], returned zero-extended to 64 bits.
- R9: An element index at or above the element count of the format (16, 8, 4, 2) wraps modulo that count.
- R10: The two vector read ports address registers independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 5 | Vector read port A register index |
| rd_a_data | output | 128 | Vector read port A data |
| rd_b_idx | input | 5 | Vector read port B register index |
| rd_b_data | output | 128 | Vector read port B data |
| vw_en | input | 1 | Vector write enable |
| vw_idx | input | 5 | Vector write register index |
| vw_full | input | 1 | 1: write all 128 bits; 0: write bits 63:0 only |
| vw_data | input | 128 | Vector write data |
| sw_en | input | 1 | Scalar write enable |
| sw_idx | input | 5 | Scalar write register index |
| sw_data | input | 64 | Scalar write data |
| sw_rd_idx | input | 5 | Scalar read register index |
| sw_rd_data | output | 64 | Scalar read data (bits 63:0 of the register) |
| wr_clash | output | 1 | Vector and scalar writes target one register this cycle |
| ex_idx | input | 5 | Extract port register index |
| ex_fmt | input | 2 | Element format code |
| ex_elem | input | 4 | Element index |
| ex_data | output | 64 | Extracted element, zero-extended |

## Verification
The checks assume every input is driven to a known value from the first clock on and that reset is held high at time zero, so that no history from before reset is ever compared. The persistence checks look one cycle back and fire only when no write at all is pending in the observing cycle, so the bench holds both write enables low in the cycle it inspects stored contents and raises them only for the write and bypass cases. All index inputs are full 5-bit values, so every register is always legal to address.

// File: rtl/vrf_pkg.sv
package vrf_pkg;

  typedef enum logic [1:0] {
    FMT_BYTE = 2'd0,
    FMT_HALF = 2'd1,
    FMT_WORD = 2'd2,
    FMT_DBL  = 2'd3
  } elem_fmt_e;

  // Value a row takes after this cycle's writes; vector write has priority.
  function automatic logic [127:0] merge_row(
    input logic [127:0] old_row,
    input logic         vec_hit,
    input logic         vec_full,
    input logic [127:0] vec_data,
    input logic         sc_hit,
    input logic [63:0]  sc_data
  );
    logic [127:0] r;
    r = old_row;
    if (vec_hit) begin
      if (vec_full) r = vec_data;
      else          r = {old_row[127:64], vec_data[63:0]};
    end else if (sc_hit) begin
      r = {64'h0, sc_data};
    end
    return r;
  endfunction

endpackage

// File: rtl/vrf_write_arb.sv
module vrf_write_arb #(
  parameter int IW = 5
) (
  input  logic          vw_en,
  input  logic [IW-1:0] vw_idx,
  input  logic          sw_en,
  input  logic [IW-1:0] sw_idx,
  output logic          sw_go,
  output logic          clash
);

  always_comb begin
    clash = vw_en && sw_en && (vw_idx == sw_idx);
    sw_go = sw_en && !clash;
  end

endmodule

// File: rtl/vrf_storage.sv
module vrf_storage #(
  parameter int NREG = 32,
  parameter int VW   = 128,
  parameter int SW   = 64,
  parameter int IW   = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     vw_en,
  input  logic [IW-1:0]            vw_idx,
  input  logic                     vw_full,
  input  logic [VW-1:0]            vw_data,
  input  logic                     sw_go,
  input  logic [IW-1:0]            sw_idx,
  input  logic [SW-1:0]            sw_data,
  output logic [NREG-1:0][VW-1:0]  rows
);

  import vrf_pkg::*;

  for (genvar r = 0; r < NREG; r++) begin : g_row
    logic vh, sh;
    assign vh = vw_en && (vw_idx == IW'(r));
    assign sh = sw_go && (sw_idx == IW'(r));
    always_ff @(posedge clk) begin
      if (rst) rows[r] <= '0;
      else if (vh || sh)
        rows[r] <= merge_row(rows[r], vh, vw_full, vw_data, sh, sw_data);
    end
  end

endmodule

// File: rtl/vrf_read_port.sv
module vrf_read_port #(
  parameter int NREG = 32,
  parameter int VW   = 128,
  parameter int SW   = 64,
  parameter int IW   = $clog2(NREG)
) (
  input  logic [IW-1:0]            idx,
  input  logic [NREG-1:0][VW-1:0]  rows,
  input  logic                     vw_en,
  input  logic [IW-1:0]            vw_idx,
  input  logic                     vw_full,
  input  logic [VW-1:0]            vw_data,
  input  logic                     sw_go,
  input  logic [IW-1:0]            sw_idx,
  input  logic [SW-1:0]            sw_data,
  output logic [VW-1:0]            row
);

  import vrf_pkg::*;

  always_comb begin
    row = merge_row(rows[idx],
                    vw_en && (vw_idx == idx), vw_full, vw_data,
                    sw_go && (sw_idx == idx), sw_data);
  end

endmodule

// File: rtl/vrf_elem_extract.sv
module vrf_elem_extract #(
  parameter int VW = 128,
  parameter int SW = 64,
  parameter int EW = $clog2(VW / 8)
) (
  input  logic [VW-1:0] row,
  input  logic [1:0]    fmt,
  input  logic [EW-1:0] elem,
  output logic [SW-1:0] data
);

  import vrf_pkg::*;

  localparam int BW = $clog2(VW);

  logic [BW-1:0] base;
  logic [SW-1:0] window;

  always_comb begin
    // Truncation to BW bits wraps the index modulo the element count.
    base   = BW'({elem, 3'b000} << fmt);
    window = SW'(row >> base);
    unique case (elem_fmt_e'(fmt))
      FMT_BYTE: data = SW'(window[7:0]);
      FMT_HALF: data = SW'(window[15:0]);
      FMT_WORD: data = SW'(window[31:0]);
      default:  data = window;
    endcase
  end

endmodule

// File: rtl/vreg_alias_file.sv
module vreg_alias_file #(
  parameter int NREG = 32,
  parameter int VW   = 128,
  parameter int SW   = 64,
  parameter int IW   = $clog2(NREG),
  parameter int EW   = $clog2(VW / 8)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] rd_a_idx,
  output logic [VW-1:0] rd_a_data,
  input  logic [IW-1:0] rd_b_idx,
  output logic [VW-1:0] rd_b_data,
  input  logic          vw_en,
  input  logic [IW-1:0] vw_idx,
  input  logic          vw_full,
  input  logic [VW-1:0] vw_data,
  input  logic          sw_en,
  input  logic [IW-1:0] sw_idx,
  input  logic [SW-1:0] sw_data,
  input  logic [IW-1:0] sw_rd_idx,
  output logic [SW-1:0] sw_rd_data,
  output logic          wr_clash,
  input  logic [IW-1:0] ex_idx,
  input  logic [1:0]    ex_fmt,
  input  logic [EW-1:0] ex_elem,
  output logic [SW-1:0] ex_data
);

  localparam int NPORT = 4;

  logic                    sw_go;
  logic [NREG-1:0][VW-1:0] rows;
  logic [NPORT-1:0][IW-1:0] port_idx;
  logic [NPORT-1:0][VW-1:0] port_row;

  vrf_write_arb #(.IW(IW)) u_arb (
    .vw_en (vw_en), .vw_idx(vw_idx),
    .sw_en (sw_en), .sw_idx(sw_idx),
    .sw_go (sw_go), .clash (wr_clash)
  );

  vrf_storage #(.NREG(NREG), .VW(VW), .SW(SW), .IW(IW)) u_store (
    .clk(clk), .rst(rst),
    .vw_en(vw_en), .vw_idx(vw_idx), .vw_full(vw_full), .vw_data(vw_data),
    .sw_go(sw_go), .sw_idx(sw_idx), .sw_data(sw_data),
    .rows(rows)
  );

  assign port_idx[0] = rd_a_idx;
  assign port_idx[1] = rd_b_idx;
  assign port_idx[2] = sw_rd_idx;
  assign port_idx[3] = ex_idx;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    vrf_read_port #(.NREG(NREG), .VW(VW), .SW(SW), .IW(IW)) u_rd (
      .idx(port_idx[p]), .rows(rows),
      .vw_en(vw_en), .vw_idx(vw_idx), .vw_full(vw_full), .vw_data(vw_data),
      .sw_go(sw_go), .sw_idx(sw_idx), .sw_data(sw_data),
      .row(port_row[p])
    );
  end

  assign rd_a_data  = port_row[0];
  assign rd_b_data  = port_row[1];
  assign sw_rd_data = port_row[2][SW-1:0];

  vrf_elem_extract #(.VW(VW), .SW(SW), .EW(EW)) u_ext (
    .row(port_row[3]), .fmt(ex_fmt), .elem(ex_elem), .data(ex_data)
  );

endmodule

// File: rtl/vrf_checker.sv
module vrf_checker #(
  parameter int NREG = 32,
  parameter int VW   = 128,
  parameter int SW   = 64,
  parameter int IW   = $clog2(NREG),
  parameter int EW   = $clog2(VW / 8)
) (
  input logic          clk,
  input logic          rst,
  input logic [IW-1:0] rd_a_idx,
  input logic [VW-1:0] rd_a_data,
  input logic [IW-1:0] rd_b_idx,
  input logic [VW-1:0] rd_b_data,
  input logic          vw_en,
  input logic [IW-1:0] vw_idx,
  input logic          vw_full,
  input logic [VW-1:0] vw_data,
  input logic          sw_en,
  input logic [IW-1:0] sw_idx,
  input logic [SW-1:0] sw_data,
  input logic [IW-1:0] sw_rd_idx,
  input logic [SW-1:0] sw_rd_data,
  input logic          wr_clash,
  input logic [IW-1:0] ex_idx,
  input logic [1:0]    ex_fmt,
  input logic [EW-1:0] ex_elem,
  input logic [SW-1:0] ex_data
);

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) && !vw_en && !sw_en |-> rd_a_data == '0);

  // R2
  vfull_store_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(vw_en && vw_full) && !vw_en && !sw_en
      && rd_a_idx == $past(vw_idx) |-> rd_a_data == $past(vw_data));

  // R3
  half_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(vw_en && !vw_full) && $past(rd_a_idx) == $past(vw_idx)
      && !vw_en && !sw_en && rd_a_idx == $past(vw_idx)
      |-> rd_a_data[VW-1:SW] == $past(rd_a_data[VW-1:SW])
          && rd_a_data[SW-1:0] == $past(vw_data[SW-1:0]));

  // R4
  sw_store_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(sw_en && !(vw_en && vw_idx == sw_idx))
      && !vw_en && !sw_en && rd_b_idx == $past(sw_idx)
      |-> rd_b_data == {{(VW-SW){1'b0}}, $past(sw_data)});

  // R5
  alias_chk: assert property (@(posedge clk) disable iff (rst)
    sw_rd_idx == rd_a_idx |-> sw_rd_data == rd_a_data[SW-1:0]);

  // R6
  clash_win_chk: assert property (@(posedge clk) disable iff (rst)
    wr_clash && vw_full && rd_a_idx == vw_idx |-> rd_a_data == vw_data);

  // R7
  bypass_chk: assert property (@(posedge clk) disable iff (rst)
    vw_en && vw_full && rd_b_idx == vw_idx |-> rd_b_data == vw_data);

  // R8
  dbl_alias_chk: assert property (@(posedge clk) disable iff (rst)
    ex_fmt == 2'd3 && !ex_elem[0] && ex_idx == sw_rd_idx |-> ex_data == sw_rd_data);

endmodule

bind vreg_alias_file vrf_checker #(
  .NREG(NREG), .VW(VW), .SW(SW), .IW(IW), .EW(EW)
) u_chk (
  .clk(clk), .rst(rst),
  .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
  .vw_en(vw_en), .vw_idx(vw_idx), .vw_full(vw_full), .vw_data(vw_data),
  .sw_en(sw_en), .sw_idx(sw_idx), .sw_data(sw_data),
  .sw_rd_idx(sw_rd_idx), .sw_rd_data(sw_rd_data), .wr_clash(wr_clash),
  .ex_idx(ex_idx), .ex_fmt(ex_fmt), .ex_elem(ex_elem), .ex_data(ex_data)
);

// File: tb/vreg_alias_file_bench.sv
module vreg_alias_file_bench;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [4:0]   rd_a_idx = '0, rd_b_idx = '0, vw_idx = '0, sw_idx = '0;
  logic [4:0]   sw_rd_idx = '0, ex_idx = '0;
  logic [127:0] rd_a_data, rd_b_data, vw_data = '0;
  logic         vw_en = 1'b0, vw_full = 1'b0, sw_en = 1'b0, wr_clash;
  logic [63:0]  sw_data = '0, sw_rd_data, ex_data;
  logic [1:0]   ex_fmt = '0;
  logic [3:0]   ex_elem = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  vreg_alias_file u_vreg_alias_file (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .vw_en(vw_en), .vw_idx(vw_idx), .vw_full(vw_full), .vw_data(vw_data),
    .sw_en(sw_en), .sw_idx(sw_idx), .sw_data(sw_data),
    .sw_rd_idx(sw_rd_idx), .sw_rd_data(sw_rd_data), .wr_clash(wr_clash),
    .ex_idx(ex_idx), .ex_fmt(ex_fmt), .ex_elem(ex_elem), .ex_data(ex_data)
  );

  localparam logic [127:0] PAT = 128'hFFEEDDCCBBAA99887766554433221100;
  localparam logic [127:0] QAT = 128'h0123456789ABCDEF_FEDCBA9876543210;

  // {format, element index, expected zero-extended element} on PAT
  localparam int NX = 10;
  localparam logic [69:0] XT [NX] = '{
    {2'd0, 4'd0,  64'h00},
    {2'd0, 4'd15, 64'hFF},
    {2'd0, 4'd7,  64'h77},
    {2'd1, 4'd3,  64'h7766},
    {2'd1, 4'd9,  64'h3322},
    {2'd2, 4'd2,  64'hBBAA9988},
    {2'd2, 4'd5,  64'h77665544},
    {2'd3, 4'd1,  64'hFFEEDDCCBBAA9988},
    {2'd3, 4'd2,  64'h7766554433221100},
    {2'd3, 4'd15, 64'hFFEEDDCCBBAA9988}
  };

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive after the edge, let the next edge commit, release.
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle_writes();
    vw_en = 1'b0; sw_en = 1'b0;
  endtask

  initial begin
    step(); step(); step();
    rst = 1'b0;
    step();
    // R1: cleared after reset
    rd_a_idx = 5'd0; rd_b_idx = 5'd31; sw_rd_idx = 5'd7; ex_idx = 5'd3; ex_fmt = 2'd3;
    #4;
    chk("R1 read A", rd_a_data, '0);
    chk("R1 read B", rd_b_data, '0);
    chk("R1 scalar", {64'h0, sw_rd_data}, '0);
    chk("R1 extract", {64'h0, ex_data}, '0);

    // R7: pending full write visible before the edge
    step();
    vw_en = 1'b1; vw_idx = 5'd5; vw_full = 1'b1; vw_data = PAT; rd_a_idx = 5'd5;
    #4;
    chk("R7 bypass A", rd_a_data, PAT);
    chk("R6 no clash", {127'h0, wr_clash}, 128'h0);
    step(); idle_writes();
    // R2 + R10: both ports, independent indices
    rd_b_idx = 5'd5; rd_a_idx = 5'd6;
    #4;
    chk("R2 port B", rd_b_data, PAT);
    chk("R10 port A other reg", rd_a_data, '0);

    // R8 / R9: element extraction table
    ex_idx = 5'd5;
    for (int i = 0; i < NX; i++) begin
      ex_fmt = XT[i][69:68]; ex_elem = XT[i][67:64];
      #1;
      chk((XT[i][67:64] >= (4'd8 >> XT[i][69:68]) * 2) ? "R9 wrap" : "R8 extract",
          {64'h0, ex_data}, {64'h0, XT[i][63:0]});
    end

    // R5: scalar view of register 5
    sw_rd_idx = 5'd5; #1;
    chk("R5 scalar alias", {64'h0, sw_rd_data}, {64'h0, PAT[63:0]});

    // R4: scalar write clears the upper half; R7 scalar bypass
    step();
    sw_en = 1'b1; sw_idx = 5'd5; sw_data = 64'h1234_5678_9ABC_DEF0;
    #4;
    chk("R7 scalar bypass", {64'h0, sw_rd_data}, {64'h0, 64'h1234_5678_9ABC_DEF0});
    step(); idle_writes();
    rd_a_idx = 5'd5; #4;
    chk("R4 upper cleared", rd_a_data, {64'h0, 64'h1234_5678_9ABC_DEF0});

    // R3: low-half vector write keeps the upper half
    vw_en = 1'b1; vw_idx = 5'd9; vw_full = 1'b1; vw_data = QAT;
    step();
    vw_full = 1'b0; vw_data = {64'hDEAD_DEAD_DEAD_DEAD, 64'hCAFE_0000_BEEF_1111};
    step(); idle_writes();
    rd_b_idx = 5'd9; #4;
    chk("R3 half write", rd_b_data, {QAT[127:64], 64'hCAFE_0000_BEEF_1111});

    // R6: clash, vector wins
    vw_en = 1'b1; vw_idx = 5'd12; vw_full = 1'b1; vw_data = QAT;
    sw_en = 1'b1; sw_idx = 5'd12; sw_data = 64'hAAAA_BBBB_CCCC_DDDD;
    #4;
    chk("R6 clash flag", {127'h0, wr_clash}, 128'h1);
    step(); idle_writes();
    rd_a_idx = 5'd12; #4;
    chk("R6 vector wins", rd_a_data, QAT);

    // Boundary registers 0 and 31 together, R10 independent ports
    vw_en = 1'b1; vw_idx = 5'd31; vw_full = 1'b1; vw_data = ~PAT;
    sw_en = 1'b1; sw_idx = 5'd0;  sw_data = 64'h0F0F_0F0F_0F0F_0F0F;
    #4;
    chk("R6 distinct regs no clash", {127'h0, wr_clash}, 128'h0);
    step(); idle_writes();
    rd_a_idx = 5'd0; rd_b_idx = 5'd31; #4;
    chk("R10 port A reg0", rd_a_data, {64'h0, 64'h0F0F_0F0F_0F0F_0F0F});
    chk("R2 port B reg31", rd_b_data, ~PAT);

    // R1: reset again clears stored data
    rst = 1'b1; step(); rst = 1'b0; #4;
    chk("R1 reset clears", rd_b_data, '0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule